// File: doc/BRIEF.md
# Timer with Capture/Compare Channel

This block is a 16-bit up-counter paired with one capture/compare channel, set up and read through a byte-wide register port. The counter advances on every system clock (internal mode) or on rising edges of an asynchronous external count input (external mode). In external mode the counter stays idle until a falling edge has been seen on that input after the timer was started.

The channel has four modes:
- **off**: the channel does nothing.
- **capture**: a capture event copies the live count into the channel register.
- **compare**: equality between the channel register and the running count sets the channel flag.
- **period**: a compare match also clears the counter on the next clock, so the channel register works as a period register.

The block has a sticky overflow flag and a sticky channel flag. One interrupt request output is gated by per-source enables, a peripheral enable and a global enable.

Top module: `tmr_ccp_unit`

## Requirements
- R1: When the counter advances from 16'hFFFF it wraps to 16'h0000 and sets the overflow flag (flags register bit 0).
- R2: `irq` is high exactly when the global enable (enable register bit 3) and the peripheral enable (bit 2) are both set, and at least one of the following holds: the timer runs (control bit 0) with the overflow enable (bit 0) and the overflow flag set; or the channel enable (bit 1) and the channel flag are set.
- R3: Both flags are sticky. A write to the flags register (address 5) loads bit 0 into the overflow flag and bit 1 into the channel flag. A hardware set in the same cycle wins over the write.
- R4: In capture mode (control bits [3:2] = 1), a one-cycle `cap_evt` pulse copies the count present in that cycle into the channel register and sets the channel flag.
- R5: In compare mode (control bits [3:2] = 2), the channel flag is set whenever the timer runs and the channel register equals the count. The counter keeps counting.
- R6: In period mode (control bits [3:2] = 3), a match with value P clears the counter to 0 on the next clock instead of incrementing it, giving a period of P+1 ticks. This clear never sets the overflow flag, but it does set the channel flag.
- R7: A write to counter byte address 0 (low) or 1 (high) in the same cycle as a period clear loads the written byte. The clear is dropped and the other byte is kept.
- R8: External mode is selected by control bit 1. The input passes a two-flop synchronizer, and a rising edge advances the count two clocks after it is sampled. After the timer starts, no edge counts until a falling edge has been seen; after that, each rising edge adds exactly one.
- R9: With control bit 0 clear the count holds and no compare match is raised. Stopping the timer re-arms the falling-edge requirement of R8.
- R10: The registers read back through `rd_data` at these addresses: 0 and 1 count bytes, 2 and 3 channel bytes, 4 control, 5 flags, 6 enables, 7 reads zero. All of them reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_cnt | input | 1 | Asynchronous external count input |
| cap_evt | input | 1 | Capture event pulse, system clock domain |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Register write data |
| rd_data | output | 8 | Register read data for `addr` (combinational) |
| ovf_flag | output | 1 | Sticky overflow flag |
| ch_flag | output | 1 | Sticky channel flag |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench targets the following corner cases:
- **Wrap at full scale.** A design that wraps wrongly, or forgets the flag, shows a wrong count or a missing overflow.
- **Period clear.** A design that lets the period clear set the overflow flag, or that clears one clock late, counts past P.
- **Counter write in the clearing cycle.** A design that lets the clear win returns zero instead of the written byte.
- **External edges.** The bench sends a rising edge before any falling edge, both right after enabling and again after a stop and restart. A design that skips the arming step counts one extra.
- **Per-cycle comparison.** A reference model checks the flags, the interrupt and the read data every cycle, so an off-by-one in synchronizer latency or interrupt gating shows up at once.

// File: rtl/tmr_pkg.sv
// Shared definitions for the timer/channel block: register addresses and channel modes.
package tmr_pkg;
    localparam logic [2:0] A_CNT_LO = 3'd0;
    localparam logic [2:0] A_CNT_HI = 3'd1;
    localparam logic [2:0] A_CH_LO  = 3'd2;
    localparam logic [2:0] A_CH_HI  = 3'd3;
    localparam logic [2:0] A_CTRL   = 3'd4;
    localparam logic [2:0] A_FLAGS  = 3'd5;
    localparam logic [2:0] A_IEN    = 3'd6;

    typedef enum logic [1:0] {
        CH_OFF     = 2'd0,
        CH_CAPTURE = 2'd1,
        CH_COMPARE = 2'd2,
        CH_PERIOD  = 2'd3
    } ch_mode_t;
endpackage

// File: rtl/tmr_ext_edge.sv
// External count front end: synchronizes an asynchronous input, arms on the
// first falling edge after the timer runs, then emits one pulse per rising edge.
// Assumes the input is slower than half the system clock.
module tmr_ext_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    input  logic run,
    output logic inc
);
    logic [STAGES:0] pipe;
    logic            armed;
    logic            rise, fall;

    // First synchronizer stage samples the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= 1'b0;
        else        pipe[0] <= ext_in;
    end

    // Remaining synchronizer stages plus one history flop.
    generate
        for (genvar i = 1; i <= STAGES; i++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[i] <= 1'b0;
                else        pipe[i] <= pipe[i-1];
            end
        end
    endgenerate

    assign rise = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall = ~pipe[STAGES-1] & pipe[STAGES];

    // Arm on a falling edge while running; disarm whenever stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)    armed <= 1'b0;
        else if (!run) armed <= 1'b0;
        else if (fall) armed <= 1'b1;
    end

    assign inc = run & armed & rise;

    assert_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !inc);
endmodule

// File: rtl/tmr_count.sv
// Up-counter with byte loads. Priority: byte write, then clear, then step.
// Reports a wrap pulse when a step leaves the all-ones value.
module tmr_count #(
    parameter int BYTE_W = 8,
    localparam int W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              clr,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic [W-1:0]      cnt,
    output logic              wrap
);
    logic load;
    assign load = wr_lo | wr_hi;
    assign wrap = step & ~load & ~clr & (&cnt);

    // Count register update with write-over-clear-over-step priority.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (wr_lo) cnt[BYTE_W-1:0] <= wdata;
        else if (wr_hi) cnt[W-1:BYTE_W] <= wdata;
        else if (clr)   cnt <= '0;
        else if (step)  cnt <= cnt + 1'b1;
    end

    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !load) |=> cnt == '0);
    assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && clr) |=> cnt[BYTE_W-1:0] == $past(wdata));
endmodule

// File: rtl/tmr_chan.sv
// Capture/compare channel: holds the channel register, captures the count on
// an event, and detects matches; in period mode it requests a counter clear.
module tmr_chan #(
    parameter int BYTE_W = 8,
    localparam int W = 2 * BYTE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  tmr_pkg::ch_mode_t   mode,
    input  logic                run,
    input  logic                cap_evt,
    input  logic [W-1:0]        cnt,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [W-1:0]        ch_val,
    output logic                ch_set,
    output logic                clr
);
    import tmr_pkg::*;
    logic match, capture;

    assign match   = run & (mode == CH_COMPARE || mode == CH_PERIOD) & (ch_val == cnt);
    assign capture = (mode == CH_CAPTURE) & cap_evt;
    assign clr     = match & (mode == CH_PERIOD);
    assign ch_set  = match | capture;

    // Channel register: software byte writes beat a capture.
    always_ff @(posedge clk) begin
        if (!rst_n)       ch_val <= '0;
        else if (wr_lo)   ch_val[BYTE_W-1:0] <= wdata;
        else if (wr_hi)   ch_val[W-1:BYTE_W] <= wdata;
        else if (capture) ch_val <= cnt;
    end

    assert_capture_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CH_CAPTURE && cap_evt && !wr_lo && !wr_hi) |=> ch_val == $past(cnt));
endmodule

// File: rtl/tmr_ccp_unit.sv
// Top of the timer with one capture/compare channel. Holds control, enable and
// flag registers, the read mux and the interrupt gate. The capture event is
// assumed synchronous to clk; the external count input may be asynchronous.
module tmr_ccp_unit #(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_cnt,
    input  logic              cap_evt,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rd_data,
    output logic              ovf_flag,
    output logic              ch_flag,
    output logic              irq
);
    import tmr_pkg::*;
    localparam int W = 2 * BYTE_W;

    logic [3:0]   ctrl_q, ien_q;
    logic         run, ext_mode, ext_inc, step, wrap, ch_set, clr;
    logic         wr_cnt_lo, wr_cnt_hi, wr_ch_lo, wr_ch_hi, wr_flags;
    logic [W-1:0] cnt, ch_val;
    ch_mode_t     mode;

    assign run       = ctrl_q[0];
    assign ext_mode  = ctrl_q[1];
    assign mode      = ch_mode_t'(ctrl_q[3:2]);
    assign wr_cnt_lo = wr_en && addr == A_CNT_LO;
    assign wr_cnt_hi = wr_en && addr == A_CNT_HI;
    assign wr_ch_lo  = wr_en && addr == A_CH_LO;
    assign wr_ch_hi  = wr_en && addr == A_CH_HI;
    assign wr_flags  = wr_en && addr == A_FLAGS;
    assign step      = run & (ext_mode ? ext_inc : 1'b1);

    tmr_ext_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_cnt), .run(run), .inc(ext_inc));

    tmr_count #(.BYTE_W(BYTE_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .step(step), .clr(clr),
        .wr_lo(wr_cnt_lo), .wr_hi(wr_cnt_hi), .wdata(wdata),
        .cnt(cnt), .wrap(wrap));

    tmr_chan #(.BYTE_W(BYTE_W)) u_chan (
        .clk(clk), .rst_n(rst_n), .mode(mode), .run(run), .cap_evt(cap_evt),
        .cnt(cnt), .wr_lo(wr_ch_lo), .wr_hi(wr_ch_hi), .wdata(wdata),
        .ch_val(ch_val), .ch_set(ch_set), .clr(clr));

    // Control and enable registers, loaded by software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ien_q  <= '0;
        end else if (wr_en) begin
            if (addr == A_CTRL) ctrl_q <= wdata[3:0];
            if (addr == A_IEN)  ien_q  <= wdata[3:0];
        end
    end

    // Sticky flags: software load, hardware set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            ch_flag  <= 1'b0;
        end else begin
            ovf_flag <= (wr_flags ? wdata[0] : ovf_flag) | wrap;
            ch_flag  <= (wr_flags ? wdata[1] : ch_flag)  | ch_set;
        end
    end

    // Read mux over the register map.
    always_comb begin
        rd_data = '0;
        case (addr)
            A_CNT_LO: rd_data = cnt[BYTE_W-1:0];
            A_CNT_HI: rd_data = cnt[W-1:BYTE_W];
            A_CH_LO:  rd_data = ch_val[BYTE_W-1:0];
            A_CH_HI:  rd_data = ch_val[W-1:BYTE_W];
            A_CTRL:   rd_data[3:0] = ctrl_q;
            A_FLAGS:  rd_data[1:0] = {ch_flag, ovf_flag};
            A_IEN:    rd_data[3:0] = ien_q;
            default:  rd_data = '0;
        endcase
    end

    assign irq = ien_q[3] & ien_q[2] &
                 ((run & ien_q[0] & ovf_flag) | (ien_q[1] & ch_flag));

    assert_wrap_sets_ovf_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ovf_flag);
    assert_irq_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien_q[3] && ien_q[2]));
    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !wr_flags) |=> ovf_flag);
    assert_clear_no_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !ovf_flag && !wr_flags) |=> !ovf_flag);
    assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_cnt_lo && !wr_cnt_hi) |=> $stable(cnt));
endmodule

// File: tb/sim_tmr_ccp_unit.sv
module sim_tmr_ccp_unit;
    logic       clk = 1'b0, rst_n = 1'b0, ext_cnt = 1'b0, cap_evt = 1'b0, wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0, rd_data;
    logic       ovf_flag, ch_flag, irq;
    int nchk = 0, nerr = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tmr_ccp_unit u0 (.clk(clk), .rst_n(rst_n), .ext_cnt(ext_cnt), .cap_evt(cap_evt),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rd_data(rd_data),
        .ovf_flag(ovf_flag), .ch_flag(ch_flag), .irq(irq));

    // Behavioural reference model
    logic [15:0] m_cnt = 0, m_ch = 0;
    logic [3:0]  m_ctrl = 0, m_ien = 0;
    logic        m_ovf = 0, m_chf = 0, m_arm = 0;
    logic        q_ext [$] = '{1'b0, 1'b0, 1'b0};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_ch = 0; m_ctrl = 0; m_ien = 0; m_ovf = 0; m_chf = 0; m_arm = 0;
            q_ext = '{1'b0, 1'b0, 1'b0};
        end else begin
            bit run, rise, fall, step, match, clr, wrp, chs;
            logic [1:0] mode;
            run  = m_ctrl[0];
            mode = m_ctrl[3:2];
            rise = q_ext[1] && !q_ext[2];
            fall = !q_ext[1] && q_ext[2];
            step = run && (m_ctrl[1] ? (m_arm && rise) : 1'b1);
            match = run && mode >= 2 && m_ch == m_cnt;
            clr = match && mode == 3;
            chs = match || (mode == 1 && cap_evt);
            wrp = 0;
            if (!run) m_arm = 0; else if (fall) m_arm = 1;
            if (mode == 1 && cap_evt && !(wr_en && (addr == 2 || addr == 3))) m_ch = m_cnt;
            if (wr_en && addr == 0) m_cnt[7:0] = wdata;
            else if (wr_en && addr == 1) m_cnt[15:8] = wdata;
            else if (clr) m_cnt = 0;
            else if (step) begin wrp = (m_cnt == 16'hFFFF); m_cnt = m_cnt + 1; end
            if (wr_en && addr == 2) m_ch[7:0] = wdata;
            if (wr_en && addr == 3) m_ch[15:8] = wdata;
            if (wr_en && addr == 4) m_ctrl = wdata[3:0];
            if (wr_en && addr == 6) m_ien = wdata[3:0];
            if (wr_en && addr == 5) begin m_ovf = wdata[0]; m_chf = wdata[1]; end
            m_ovf = m_ovf | wrp;
            m_chf = m_chf | chs;
            void'(q_ext.pop_back());
            q_ext.push_front(ext_cnt);
        end
    end

    function automatic logic [7:0] m_read(logic [2:0] a);
        case (a)
            0: return m_cnt[7:0];
            1: return m_cnt[15:8];
            2: return m_ch[7:0];
            3: return m_ch[15:8];
            4: return {4'd0, m_ctrl};
            5: return {6'd0, m_chf, m_ovf};
            6: return {4'd0, m_ien};
            default: return 8'd0;
        endcase
    endfunction

    function automatic logic m_irq();
        return m_ien[3] && m_ien[2] &&
               ((m_ctrl[0] && m_ien[0] && m_ovf) || (m_ien[1] && m_chf));
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Every-cycle comparison shortly before the next rising edge
    always @(negedge clk) begin
        #8;
        if (rst_n && !done) begin
            chk("R1 R3 ovf_flag", ovf_flag, m_ovf);
            chk("R4 R5 ch_flag", ch_flag, m_chf);
            chk("R2 irq", irq, m_irq());
            chk("R10 rd_data", rd_data, m_read(addr));
        end
    end

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_rd(string tag, logic [2:0] a, logic [7:0] e);
        @(negedge clk); wr_en = 0; addr = a; #8;
        chk(tag, rd_data, e);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(3); rst_n = 1;
        // R10 reset state and readback
        for (int a = 0; a < 8; a++) expect_rd("R10 reset value", a[2:0], 8'h00);
        wr(2, 8'hA5); wr(3, 8'h3C); wr(6, 8'h0C);
        expect_rd("R10 channel low", 2, 8'hA5);
        expect_rd("R10 channel high", 3, 8'h3C);
        expect_rd("R10 enable readback", 6, 8'h0C);

        // R1 wrap sets overflow; R2 interrupt gating; R3 sticky
        wr(0, 8'hFA); wr(1, 8'hFF); wr(6, 8'h0D); wr(4, 8'h01);
        idle(8);
        expect_rd("R1 overflow flag after wrap", 5, 8'h01);
        chk("R2 irq with all enables", irq, 1'b1);
        wr(6, 8'h05);
        chk("R2 irq without global enable", irq, 1'b0);
        idle(20);
        expect_rd("R3 overflow still set", 5, 8'h01);
        wr(5, 8'h00);
        expect_rd("R3 overflow cleared by write", 5, 8'h00);

        // R4 capture
        wr(4, 8'h05); idle(3);
        @(negedge clk); cap_evt = 1;
        @(negedge clk); cap_evt = 0;
        expect_rd("R4 captured low byte", 2, m_ch[7:0]);
        expect_rd("R4 channel flag", 5, 8'h02);

        // R5 compare keeps counting
        wr(4, 8'h00); wr(5, 8'h00); wr(0, 8'h00); wr(1, 8'h00);
        wr(2, 8'h06); wr(3, 8'h00); wr(4, 8'h09);
        idle(12);
        expect_rd("R5 compare flag", 5, 8'h02);
        chk("R5 counter passed match", (m_cnt > 16'h0006) ? 1'b1 : 1'b0, 1'b1);

        // R6 period mode: clear after P, no overflow
        wr(4, 8'h00); wr(5, 8'h00); wr(0, 8'h00); wr(2, 8'h09); wr(4, 8'h0D);
        begin
            logic [7:0] prev = 8'hFF;
            addr = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk); #8;
                if (prev == 8'h09) chk("R6 clear after period", rd_data, 8'h00);
                prev = rd_data;
            end
        end
        expect_rd("R6 no overflow from clear", 5, 8'h02);

        // R7 write wins over clear
        do @(negedge clk); while (m_cnt != 16'h0009);
        wr_en = 1; addr = 0; wdata = 8'h55;
        @(negedge clk); wr_en = 0;
        #8 chk("R7 write beats clear", rd_data, 8'h55);

        // R8 external counting with falling-edge arming
        wr(4, 8'h00); wr(0, 8'h00); wr(1, 8'h00); wr(4, 8'h03);
        @(negedge clk); ext_cnt = 1; idle(5);
        expect_rd("R8 no count before falling edge", 0, 8'h00);
        ext_cnt = 0; idle(5);
        for (int k = 0; k < 3; k++) begin ext_cnt = 1; idle(3); ext_cnt = 0; idle(3); end
        expect_rd("R8 three rising edges", 0, 8'h03);

        // R9 freeze and re-arm
        wr(4, 8'h02);
        ext_cnt = 1; idle(3); ext_cnt = 0; idle(5);
        expect_rd("R9 frozen while stopped", 0, 8'h03);
        wr(4, 8'h03);
        ext_cnt = 1; idle(5);
        expect_rd("R9 re-armed after restart", 0, 8'h03);
        ext_cnt = 0; idle(4); ext_cnt = 1; idle(5);
        expect_rd("R8 counts after arming again", 0, 8'h04);

        idle(2);
        finish_run();
    end
endmodule